// File: doc/BRIEF.md
# Low-Power Escape Command Transmitter

This block drives the two single-ended wires of one data lane while the lane is in its low-power escape signalling. It starts from the stop state, where both wires are high. When it accepts a command byte it walks the lane through a fixed entry pattern and then sends the byte one bit at a time. Each bit is a one-hot mark followed by a space in which both wires are low. No clock travels with the data: the far end rebuilds one by taking the exclusive-OR of the two wires, so every bit gives exactly one pulse.

All line changes are paced by a single-cycle `tick` enable at the escape bit rate of 10 Mbps or less. The one exception is the first entry state, which appears on the edge that accepts the command. An ordinary command ends with a closing mark on the positive wire and a return to stop state. The ultra-low-power command (byte 0x1E) leaves the lane parked with both wires low and `busy` still high. It stays there until a wake request arrives on a tick. The block then holds a long mark on the positive wire for a programmable number of ticks before it restores the stop state.

Top module: `esc_lane_tx`

## Requirements
- R1: Out of reset, and whenever `busy` is low, the lane is in stop state (`line_p`=1, `line_n`=1), `busy` is 0 and `cmd_ready` is 1.
- R2: The line levels change only on a clock edge where `tick` is 1, except on the edge that accepts a command.
- R3: On an edge with `cmd_valid`=1 and `cmd_ready`=1, `busy` rises and {`line_p`,`line_n`} becomes 10. The next three ticks give 00, 01 and 00 in that order.
- R4: A bit of value 1 is sent as {`line_p`,`line_n`}=10 and a bit of value 0 as 01. Each mark lasts one tick and is followed by one tick of 00.
- R5: The eight bits of `cmd_data` go out most significant bit first, starting on the tick after the last entry state.
- R6: After the last bit's space of any byte other than 0x1E, the lane shows 10 for one tick, then returns to 11 with `busy` low.
- R7: After the last bit's space of byte 0x1E (binary 00011110), the lane stays at 00 with `busy` high for any number of ticks on which `wake_req` is 0.
- R8: In that parked state, a tick with `wake_req`=1 drives 10 for max(`wake_len`,1) ticks. The lane then returns to 11 with `busy` low.
- R9: While `busy` is 1, `cmd_ready` is 0, and a `cmd_valid` pulse with any byte leaves the line sequence unchanged.
- R10: `wake_req` has no effect outside the parked state: it does not alter a command in flight or the idle stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle enable at the escape bit rate |
| cmd_valid | input | 1 | Command byte offered |
| cmd_data | input | CMD_W (8) | Command byte, sent MSB first |
| cmd_ready | output | 1 | High when a command can be accepted |
| wake_req | input | 1 | Leave the parked ultra-low-power state |
| wake_len | input | WAKE_W (8) | Wake mark length in ticks (0 acts as 1) |
| line_p | output | 1 | Positive wire level |
| line_n | output | 1 | Negative wire level |
| busy | output | 1 | High from command accept until stop state returns |

## Verification
The hardest situation to reach from the ports is the parked ultra-low-power state followed by wake marks of different lengths. Only one byte out of 256 leads there, and the exit length depends on a count that is latched on the wake tick. The bench sweeps all 256 command bytes and predicts each bit's mark from the byte value. It then sends 0x1E repeatedly with wake lengths 0 through 6 and counts the 10 ticks before stop returns. Refused commands and stray wake requests are injected mid-transmission on a fixed arithmetic pattern of byte values, so the R9 and R10 cases are mixed into the sweep.

// File: rtl/esc_tx_pkg.sv
// Shared types for the escape command transmitter.
// Symbols are the pair {positive wire, negative wire}.
package esc_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ENTRY,
        PH_BITS,
        PH_TAIL,
        PH_HOLD,
        PH_WAKE
    } phase_t;

    localparam logic [1:0] SYM_STOP   = 2'b11;
    localparam logic [1:0] SYM_MARK_P = 2'b10;
    localparam logic [1:0] SYM_MARK_N = 2'b01;
    localparam logic [1:0] SYM_SPACE  = 2'b00;

    localparam int ENTRY_LEN = 4;

    // Line symbol for one step of the escape entry pattern.
    function automatic logic [1:0] entry_sym(input logic [1:0] idx);
        case (idx)
            2'd0:    return SYM_MARK_P;
            2'd2:    return SYM_MARK_N;
            default: return SYM_SPACE;
        endcase
    endfunction

    // Mark symbol for a data bit: ones on the positive wire, zeros on the negative.
    function automatic logic [1:0] bit_sym(input logic b);
        return b ? SYM_MARK_P : SYM_MARK_N;
    endfunction

endpackage

// File: rtl/esc_cmd_shreg.sv
// Command shift register. It holds the byte being sent and presents the
// current head bit and the one behind it. It counts the bits left to send
// and flags whether the byte is the ultra-low-power code.
// Assumes load and advance are never asserted together, and CMD_W >= 2.
module esc_cmd_shreg #(
    parameter int          CMD_W     = 8,
    parameter logic [CMD_W-1:0] ULPS_CODE = 8'b0001_1110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] load_data,
    input  logic             advance,
    output logic             head_bit,
    output logic             next_bit,
    output logic             last_bit,
    output logic             is_ulps
);
    localparam int CNT_W = (CMD_W > 2) ? $clog2(CMD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CMD_W - 1);

    logic [CMD_W-1:0] data_q;
    logic [CNT_W-1:0] left_q;
    logic             ulps_q;

    // Load a new byte or shift toward the MSB as each bit completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            left_q <= '0;
            ulps_q <= 1'b0;
        end else if (load) begin
            data_q <= load_data;
            left_q <= CNT_INIT;
            ulps_q <= (load_data == ULPS_CODE);
        end else if (advance) begin
            data_q <= {data_q[CMD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign head_bit = data_q[CMD_W-1];
    assign next_bit = data_q[CMD_W-2];
    assign last_bit = (left_q == '0);
    assign is_ulps  = ulps_q;

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (left_q != '0)); // R5

endmodule

// File: rtl/esc_wake_timer.sv
// Wake mark timer. It loads the requested length, with zero raised to one,
// and counts ticks while the wake mark is on the line. It flags the final tick.
// Assumes load is asserted only while run is low.
module esc_wake_timer #(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAKE_W-1:0] len,
    input  logic              run,
    input  logic              tick,
    output logic              done
);
    logic [WAKE_W-1:0] cnt_q;

    // Load the length, then count down once per tick during the wake mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? WAKE_W'(1) : len;
        end else if (run && tick && cnt_q != WAKE_W'(1)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == WAKE_W'(1));

    AST_WAKE_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0)); // R8

endmodule

// File: rtl/esc_seq_ctrl.sv
// Sequence controller. It walks the lane through stop, entry, bit
// mark/space pairs, then either the closing mark or the parked state and
// wake mark. It holds the registered line symbol.
// Assumes tick is a one-cycle enable and that the shift register and timer
// answer combinationally from their own registers.
module esc_seq_ctrl
    import esc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic       wake_req,
    input  logic       head_bit,
    input  logic       next_bit,
    input  logic       last_bit,
    input  logic       is_ulps,
    input  logic       wake_done,
    output logic       load_cmd,
    output logic       advance,
    output logic       wake_load,
    output logic       wake_run,
    output phase_t     phase,
    output logic [1:0] sym
);
    phase_t     phase_q, phase_d;
    logic [1:0] sub_q, sub_d;
    logic       space_q, space_d;
    logic [1:0] sym_q, sym_d;

    // Next-state and next-symbol decision; everything but accept waits for a tick.
    always_comb begin
        phase_d   = phase_q;
        sub_d     = sub_q;
        space_d   = space_q;
        sym_d     = sym_q;
        load_cmd  = 1'b0;
        advance   = 1'b0;
        wake_load = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (cmd_valid) begin
                    load_cmd = 1'b1;
                    phase_d  = PH_ENTRY;
                    sub_d    = 2'd0;
                    sym_d    = entry_sym(2'd0);
                end
            end
            PH_ENTRY: begin
                if (tick) begin
                    if (sub_q == 2'(ENTRY_LEN - 1)) begin
                        phase_d = PH_BITS;
                        space_d = 1'b0;
                        sym_d   = bit_sym(head_bit);
                    end else begin
                        sub_d = sub_q + 2'd1;
                        sym_d = entry_sym(sub_q + 2'd1);
                    end
                end
            end
            PH_BITS: begin
                if (tick) begin
                    if (!space_q) begin
                        space_d = 1'b1;
                        sym_d   = SYM_SPACE;
                    end else if (last_bit) begin
                        phase_d = is_ulps ? PH_HOLD : PH_TAIL;
                        sym_d   = is_ulps ? SYM_SPACE : SYM_MARK_P;
                    end else begin
                        advance = 1'b1;
                        space_d = 1'b0;
                        sym_d   = bit_sym(next_bit);
                    end
                end
            end
            PH_TAIL: begin
                if (tick) begin
                    phase_d = PH_IDLE;
                    sym_d   = SYM_STOP;
                end
            end
            PH_HOLD: begin
                if (tick && wake_req) begin
                    phase_d   = PH_WAKE;
                    sym_d     = SYM_MARK_P;
                    wake_load = 1'b1;
                end
            end
            PH_WAKE: begin
                if (tick && wake_done) begin
                    phase_d = PH_IDLE;
                    sym_d   = SYM_STOP;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                sym_d   = SYM_STOP;
            end
        endcase
    end

    // State and symbol registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sub_q   <= 2'd0;
            space_q <= 1'b0;
            sym_q   <= SYM_STOP;
        end else begin
            phase_q <= phase_d;
            sub_q   <= sub_d;
            space_q <= space_d;
            sym_q   <= sym_d;
        end
    end

    assign phase    = phase_q;
    assign sym      = sym_q;
    assign wake_run = (phase_q == PH_WAKE);

    AST_HOLD_NEEDS_ULPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |-> is_ulps); // R7

endmodule

// File: rtl/esc_lane_tx.sv
// Escape command transmitter for one data lane. It accepts a byte over a
// valid/ready handshake and sends it on two single-ended wires as spaced
// one-hot marks paced by tick. The ultra-low-power byte parks the lane
// until a wake request.
// Assumes tick is synchronous to clk and high for one cycle per bit slot.
module esc_lane_tx
    import esc_tx_pkg::*;
#(
    parameter int               CMD_W     = 8,
    parameter int               WAKE_W    = 8,
    parameter logic [CMD_W-1:0] ULPS_CODE = 8'b0001_1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              cmd_ready,
    input  logic              wake_req,
    input  logic [WAKE_W-1:0] wake_len,
    output logic              line_p,
    output logic              line_n,
    output logic              busy
);
    logic       load_cmd, advance, wake_load, wake_run, wake_done;
    logic       head_bit, next_bit, last_bit, is_ulps;
    phase_t     phase;
    logic [1:0] sym;

    esc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .wake_req  (wake_req),
        .head_bit  (head_bit),
        .next_bit  (next_bit),
        .last_bit  (last_bit),
        .is_ulps   (is_ulps),
        .wake_done (wake_done),
        .load_cmd  (load_cmd),
        .advance   (advance),
        .wake_load (wake_load),
        .wake_run  (wake_run),
        .phase     (phase),
        .sym       (sym)
    );

    esc_cmd_shreg #(.CMD_W(CMD_W), .ULPS_CODE(ULPS_CODE)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_cmd),
        .load_data (cmd_data),
        .advance   (advance),
        .head_bit  (head_bit),
        .next_bit  (next_bit),
        .last_bit  (last_bit),
        .is_ulps   (is_ulps)
    );

    esc_wake_timer #(.WAKE_W(WAKE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_load),
        .len   (wake_len),
        .run   (wake_run),
        .tick  (tick),
        .done  (wake_done)
    );

    // Port mapping of the registered symbol and the phase.
    assign line_p    = sym[1];
    assign line_n    = sym[0];
    assign busy      = (phase != PH_IDLE);
    assign cmd_ready = !busy;

    AST_IDLE_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line_p && line_n)); // R1
    AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(cmd_valid && cmd_ready)) |=> $stable({line_p, line_n})); // R2
    AST_ACCEPT_STARTS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (busy && line_p && !line_n)); // R3
    AST_BUSY_NEVER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(line_p && line_n)); // R6
    AST_REFUSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready); // R9

endmodule

// File: tb/test_esc_lane_tx.sv
module test_esc_lane_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_ready;
    logic       wake_req = 1'b0;
    logic [7:0] wake_len = 8'd3;
    logic       line_p, line_n, busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    esc_lane_tx i_esc_lane_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .wake_req  (wake_req),
        .wake_len  (wake_len),
        .line_p    (line_p),
        .line_n    (line_n),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One tick: pulse, check {p,n,busy} after the edge, then check it holds a cycle (R2).
    task automatic step(input logic [1:0] exp_line, input logic exp_busy, input string req);
        logic [3:0] seen;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        seen = {1'b0, line_p, line_n, busy};
        chk(req, seen, {1'b0, exp_line, exp_busy});
        @(negedge clk);
        chk("R2 hold", {1'b0, line_p, line_n, busy}, seen);
    endtask

    task automatic send(input logic [7:0] c, input int wlen, input bit poke_busy, input bit poke_wake);
        int eff;
        chk("R1 ready idle", {2'b0, cmd_ready, busy}, 4'b0010);
        wake_len = wlen[7:0];
        cmd_valid = 1'b1;
        cmd_data = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 accept", {1'b0, line_p, line_n, busy}, 4'b0101);
        if (poke_busy) begin
            cmd_valid = 1'b1;
            cmd_data = ~c;
            chk("R9 refuse", {3'b0, cmd_ready}, 4'b0000);
        end
        if (poke_wake && c != 8'h1E) wake_req = 1'b1;
        step(2'b00, 1'b1, "R3 entry2");
        cmd_valid = 1'b0;
        step(2'b01, 1'b1, "R3 entry3");
        step(2'b00, 1'b1, "R3 entry4");
        for (int i = 7; i >= 0; i--) begin
            step(c[i] ? 2'b10 : 2'b01, 1'b1, "R4 R5 mark");
            step(2'b00, 1'b1, "R4 space");
        end
        if (c == 8'h1E) begin
            for (int k = 0; k < 3; k++) step(2'b00, 1'b1, "R7 park");
            wake_req = 1'b1;
            step(2'b10, 1'b1, "R8 wake start");
            wake_req = 1'b0;
            eff = (wlen == 0) ? 1 : wlen;
            for (int k = 1; k < eff; k++) step(2'b10, 1'b1, "R8 wake hold");
            step(2'b11, 1'b0, "R8 wake end");
        end else begin
            step(2'b10, 1'b1, "R6 closing mark");
            wake_req = 1'b0;
            step(2'b11, 1'b0, "R6 stop");
        end
        chk("R1 ready after", {2'b0, cmd_ready, busy}, 4'b0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {line_p, line_n, busy, cmd_ready}, 4'b1101);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {line_p, line_n, busy, cmd_ready}, 4'b1101);
        wake_req = 1'b1;
        step(2'b11, 1'b0, "R10 idle wake");
        wake_req = 1'b0;
        for (int c = 0; c < 256; c++)
            send(8'(c), 3, (c % 17) == 0, (c % 5) == 0);
        for (int w = 0; w <= 6; w++)
            send(8'h1E, w, w[0], 1'b0);
        step(2'b11, 1'b0, "R1 idle tick");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule